// File: doc/BRIEF.md
# Retriggerable Digital One-Shot

This block is a clocked, counter-based monostable for a single channel. Two trigger inputs of opposite edge sense and an active-low clear go through synchronizers. A valid trigger drives `q` high, with `qN` as its complement, for a number of clock cycles set by the width input. The width is scaled by a constant chosen at build time: either the full value or roughly 0.46 of it.

A valid trigger that arrives while the pulse is running starts the full interval again, so the pulse gets longer. After each accepted trigger there is a short hold-off window, and any trigger inside it is dropped. Holding the clear input low kills the pulse at once and blocks every trigger. Releasing the clear can itself fire the block when the other two inputs are already at their trigger levels.

Top module: `oneshot_pulse`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `q` is 0 and `qN` is 1.
- R2: `qN` is always the complement of `q`.
- R3: A falling edge on `trigA` while `trigB` is high fires the block. `q` goes high after the third rising clock edge that follows the pin change: two synchronizer stages and one load register.
- R4: A rising edge on `trigB` while `trigA` is low fires the block, with the same three-edge latency.
- R5: A rising edge on `clrN` fires the block when `trigA` is low and `trigB` is high at that moment, with the same three-edge latency.
- R6: No pulse starts in any of these cases: a falling edge on `trigA` with `trigB` low, a rising edge on `trigB` with `trigA` high, or a rising edge on `clrN` with `trigA` high.
- R7: The pulse lasts L clock cycles. With `SCALE_SEL`=1 (the default), L = max(1, floor(widthCfg*46/100)). With `SCALE_SEL`=0, L = max(1, widthCfg). The width is taken when the trigger is accepted.
- R8: A trigger accepted while `q` is high reloads the full L cycles from that trigger, and `q` does not drop in between.
- R9: Triggers that reach the load stage within `HOLDOFF` cycles (default 2) of an accepted trigger are ignored. The running pulse keeps its length.
- R10: While the synchronized `clrN` is low, `q` is 0 and triggers are ignored. `q` falls after the second rising edge following a fall of `clrN`, and no pulse resumes when `clrN` returns high unless R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigA | input | 1 | Trigger input, falling-edge sensitive |
| trigB | input | 1 | Trigger input, rising-edge sensitive |
| clrN | input | 1 | Clear, active low. Its rising edge can trigger |
| widthCfg | input | WIDTH_W | Nominal pulse width in clock cycles |
| q | output | 1 | Pulse output, active high |
| qN | output | 1 | Complement of `q` |

## Verification
The assertions assume that `rst` is high at the first clock edge and that `HOLDOFF` is at least one. With that, an accepted trigger can never be followed by another one in the next cycle. They also assume `widthCfg` does not change while a trigger is being accepted. The stimulus holds every input level for at least one full cycle and changes pins only on the falling clock edge. It changes `widthCfg` only while the block is idle. It returns `trigA` and `trigB` to their idle levels in an order that cannot form a valid edge, so the only pulses are the ones each test intends.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fire;   // accepted trigger: reload the pulse counter
    logic abort;  // clear active: zero the counter, force output low
  } osStrobe_t;
endpackage

// File: rtl/oneshot_sync.sv
`timescale 1ns/1ps
module oneshot_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic syncNow,
  output logic syncPrev
);
  logic [STAGES-1:0] pipe;
  logic              prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= {STAGES{RST_VAL}};
      prevQ <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prevQ <= pipe[STAGES-1];
    end
  end

  assign syncNow  = pipe[STAGES-1];
  assign syncPrev = prevQ;
endmodule

// File: rtl/oneshot_ctrl.sv
`timescale 1ns/1ps
module oneshot_ctrl
  import oneshot_pkg::*;
#(
  parameter int HOLDOFF = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      aNow,
  input  logic      aPrev,
  input  logic      bNow,
  input  logic      bPrev,
  input  logic      cNow,
  input  logic      cPrev,
  output osStrobe_t strobe
);
  localparam int HW = (HOLDOFF < 1) ? 1 : $clog2(HOLDOFF + 1);

  logic [HW-1:0] holdCnt;
  logic aFall, bRise, cRise, armed, candidate;

  assign aFall = aPrev & ~aNow;
  assign bRise = ~bPrev & bNow;
  assign cRise = ~cPrev & cNow;
  assign armed = (holdCnt == '0);

  // Three trigger routes, each gated by the level of the other input(s)
  assign candidate = (aFall & bNow) | (bRise & ~aNow) | (cRise & ~aNow & bNow);

  assign strobe.abort = ~cNow;
  assign strobe.fire  = candidate & armed & cNow;

  always_ff @(posedge clk) begin
    if (rst || strobe.abort)  holdCnt <= '0;
    else if (strobe.fire)     holdCnt <= HW'(HOLDOFF);
    else if (!armed)          holdCnt <= holdCnt - 1'b1;
  end
endmodule

// File: rtl/oneshot_datapath.sv
`timescale 1ns/1ps
module oneshot_datapath
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W   = 8,
  parameter bit SCALE_SEL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH_W-1:0] widthCfg,
  input  osStrobe_t          strobe,
  output logic               pulseOn
);
  localparam int PROD_W = WIDTH_W + 6;

  logic [WIDTH_W-1:0] rawLen, loadLen, cnt;

  generate
    if (SCALE_SEL) begin : g_frac
      logic [PROD_W-1:0] prod;
      assign prod   = PROD_W'(widthCfg) * PROD_W'(46);
      assign rawLen = WIDTH_W'(prod / PROD_W'(100));
    end else begin : g_full
      assign rawLen = widthCfg;
    end
  endgenerate

  assign loadLen = (rawLen == '0) ? WIDTH_W'(1) : rawLen;

  always_ff @(posedge clk) begin
    if (rst || strobe.abort) cnt <= '0;
    else if (strobe.fire)    cnt <= loadLen;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign pulseOn = (cnt != '0) & ~strobe.abort;
endmodule

// File: rtl/oneshot_pulse.sv
`timescale 1ns/1ps
module oneshot_pulse
  import oneshot_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter bit SCALE_SEL   = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int HOLDOFF     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trigA,
  input  logic               trigB,
  input  logic               clrN,
  input  logic [WIDTH_W-1:0] widthCfg,
  output logic               q,
  output logic               qN
);
  logic aNow, aPrev, bNow, bPrev, cNow, cPrev, pulseOn;
  osStrobe_t strobe;

  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncA (
    .clk(clk), .rst(rst), .din(trigA), .syncNow(aNow), .syncPrev(aPrev));
  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncB (
    .clk(clk), .rst(rst), .din(trigB), .syncNow(bNow), .syncPrev(bPrev));
  oneshot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncC (
    .clk(clk), .rst(rst), .din(clrN), .syncNow(cNow), .syncPrev(cPrev));

  oneshot_ctrl #(.HOLDOFF(HOLDOFF)) u_ctrl (
    .clk(clk), .rst(rst), .aNow(aNow), .aPrev(aPrev), .bNow(bNow),
    .bPrev(bPrev), .cNow(cNow), .cPrev(cPrev), .strobe(strobe));

  oneshot_datapath #(.WIDTH_W(WIDTH_W), .SCALE_SEL(SCALE_SEL)) u_dp (
    .clk(clk), .rst(rst), .widthCfg(widthCfg), .strobe(strobe), .pulseOn(pulseOn));

  assign q  = pulseOn;
  assign qN = ~pulseOn;
endmodule

// File: rtl/oneshot_pulse_chk.sv
`timescale 1ns/1ps
module oneshot_pulse_chk (
  input logic clk,
  input logic rst,
  input logic q,
  input logic qN,
  input logic fire,
  input logic abort
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !q);
  a_r2_complement: assert property (@(posedge clk) disable iff (rst) q != qN);
  a_r3_rise_from_fire: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(fire));
  a_r8_fire_sets_q: assert property (@(posedge clk) disable iff (rst)
    fire |=> (q || abort));
  a_r9_holdoff_gap: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
  a_r10_clear_low: assert property (@(posedge clk) disable iff (rst)
    abort |-> !q);
endmodule

bind oneshot_pulse oneshot_pulse_chk u_chk (
  .clk(clk), .rst(rst), .q(q), .qN(qN),
  .fire(strobe.fire), .abort(strobe.abort));

// File: tb/test_oneshot_pulse.sv
`timescale 1ns/1ps
module test_oneshot_pulse;
  localparam int WIDTH_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigA = 1'b1, trigB = 1'b0, clrN = 1'b1;
  logic [WIDTH_W-1:0] widthCfg = 8'd10;
  logic q, qN;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  oneshot_pulse i_oneshot_pulse (
    .clk(clk), .rst(rst), .trigA(trigA), .trigB(trigB), .clrN(clrN),
    .widthCfg(widthCfg), .q(q), .qN(qN));

  function automatic int expLen(input int w);
    int v = (w * 46) / 100;
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count negedges with q high, starting at the current one
  task automatic measure(output int n);
    n = 0;
    while (q && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic restoreIdle();
    trigA = 1'b1; waitN(1); trigB = 1'b0; clrN = 1'b1; waitN(4);
  endtask

  task automatic fireA();  // A falls while B high
    trigB = 1'b1; waitN(4); trigA = 1'b0;
  endtask

  task automatic fireB();  // B rises while A low
    trigA = 1'b0; waitN(4); trigB = 1'b1;
  endtask

  // R2: complement checked on every falling edge
  always @(negedge clk) if (!rst) chk(qN == ~q, "R2 qN complement", qN, ~q);

  initial begin
    int n, w;
    void'($urandom(32'h5eed_0423));
    waitN(3);
    chk(q == 1'b0 && qN == 1'b1, "R1 reset idle", q, 0);
    @(negedge clk) rst = 1'b0;
    chk(q == 1'b0, "R1 after reset", q, 0);
    waitN(4);

    // R3 latency and length
    widthCfg = 8'd100;
    fireA();
    waitN(2); chk(q == 1'b0, "R3 before third edge", q, 0);
    waitN(1); chk(q == 1'b1, "R3 after third edge", q, 1);
    measure(n); chk(n == 46, "R7 length w=100", n, 46);
    restoreIdle();

    // R6: A falls while B low
    trigA = 1'b0; waitN(8); chk(q == 1'b0, "R6 A fall with B low", q, 0);
    // R4: B rises while A low
    trigB = 1'b1;
    waitN(2); chk(q == 1'b0, "R4 before third edge", q, 0);
    waitN(1); chk(q == 1'b1, "R4 after third edge", q, 1);
    measure(n); chk(n == 46, "R4 length", n, 46);
    restoreIdle();

    // R6: B rises while A high, clear release with A high
    trigB = 1'b1; waitN(8); chk(q == 1'b0, "R6 B rise with A high", q, 0);
    clrN = 1'b0; waitN(4); clrN = 1'b1; waitN(8);
    chk(q == 1'b0, "R6 clear rise with A high", q, 0);
    restoreIdle();

    // R5 / R10: triggers during clear ignored, clear release fires
    widthCfg = 8'd20;
    clrN = 1'b0; waitN(4);
    trigA = 1'b0; trigB = 1'b1; waitN(6);
    chk(q == 1'b0, "R10 trigger while clear low", q, 0);
    clrN = 1'b1;
    waitN(2); chk(q == 1'b0, "R5 before third edge", q, 0);
    waitN(1); chk(q == 1'b1, "R5 clear release fires", q, 1);
    measure(n); chk(n == 9, "R5 length w=20", n, 9);
    restoreIdle();

    // R10: abort a running pulse
    widthCfg = 8'd200;
    fireB(); waitN(3); chk(q == 1'b1, "R10 pulse running", q, 1);
    waitN(10); clrN = 1'b0;
    waitN(2); chk(q == 1'b0, "R10 abort", q, 0);
    trigA = 1'b1; waitN(3); trigA = 1'b0; waitN(8);
    chk(q == 1'b0, "R10 trigger ignored during clear", q, 0);
    trigA = 1'b1; waitN(2); trigB = 1'b0; waitN(4); clrN = 1'b1; waitN(8);
    chk(q == 1'b0, "R10 no resume after clear", q, 0);
    restoreIdle();

    // R8: retrigger extends
    widthCfg = 8'd100;
    fireB(); waitN(3); chk(q == 1'b1, "R8 first pulse", q, 1);
    waitN(20); trigB = 1'b0; waitN(2); trigB = 1'b1;
    for (int i = 0; i < 3; i++) begin
      waitN(1); chk(q == 1'b1, "R8 q held across retrigger", q, 1);
    end
    measure(n); chk(n == 46, "R8 full reload", n, 46);
    restoreIdle();

    // R9: retrigger inside hold-off ignored
    widthCfg = 8'd50;
    trigA = 1'b0; waitN(4);
    trigB = 1'b1; waitN(1); trigB = 1'b0; waitN(1); trigB = 1'b1; waitN(1);
    chk(q == 1'b1, "R9 pulse started", q, 1);
    measure(n); chk(n == 23, "R9 length unchanged", n, 23);
    restoreIdle();

    // R7 boundaries
    foreach (widthCfg[i]) begin end
    for (int k = 0; k < 7; k++) begin
      int wl [7] = '{0, 1, 2, 3, 4, 5, 255};
      widthCfg = wl[k][7:0];
      fireA(); waitN(3);
      measure(n); chk(n == expLen(wl[k]), "R7 boundary width", n, expLen(wl[k]));
      restoreIdle();
    end

    // Random widths and trigger routes
    for (int it = 0; it < 25; it++) begin
      w = $urandom_range(0, 255);
      widthCfg = w[7:0];
      if ($urandom_range(0, 1) == 0) fireA(); else fireB();
      waitN(3);
      measure(n); chk(n == expLen(w), "R7 random width", n, expLen(w));
      restoreIdle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule